// File: doc/BRIEF.md
# Queued SPI transfer sequencer

This block is an SPI master that works through a queue of up to sixteen
transmit bytes without help from the CPU. Software first loads the transmit
queue RAM. It then writes a start pointer and an end pointer and sets the
enable bit. The sequencer sends one queue entry per chip-select frame, moving
upward through the entries until it reaches the end pointer. Each byte
received during a frame is stored in a receive RAM at the same index as the
entry that was sent.

The start pointer can be rewritten while a queue is running. The frame in
flight always completes. The next frame then comes from the newly written
entry, which lets software switch between subqueues set up in advance. With
wraparound turned on, the sequencer jumps back to the start pointer after the
end entry and keeps repeating the queue until it is halted. A halt request
only takes effect between entries.

A loopback bit feeds the outgoing serial data into the receive path, for
testing. A status flag reports halt acknowledge, and another reports a mode
fault seen on the fault input. Each of these flags can raise an interrupt,
gated by an enable bit.

Top module: `qseq_top`

## Requirements
- R1: The start-pointer register is at CPU address 1. Its value is 4 bits in bits [3:0], and bits [7:4] always read as 0. A register read returns data on `cpu_rdata` one clock after the address is presented.
- R2: The control register is at address 0. When its enable bit (bit 0) is set, frames begin at the start-pointer entry. They continue in ascending order up to and including the end-pointer entry, which is held in bits [3:0] at address 2. The queue then stops, and the queue-finished flag (status bit 0, address 3) sets. The status flags at address 3 are cleared by writing 1 to them.
- R3: Each frame shifts 8 bits, MSB first, in SPI mode 0. The clock idles low, MOSI changes on the falling clock edge, and data is sampled on the rising edge. Chip select (active low) stays asserted for the whole entry, is released between entries, and the clock is never high while chip select is released.
- R4: The byte received in a frame is written to the receive RAM slot whose index equals the entry sent. That slot can be read through `ram_raddr` / `ram_rdata`, with data one clock after the address.
- R5: Writing the start pointer while a queue runs lets the current frame finish. The very next frame is then taken from the new start-pointer entry, and counting upward continues from there.
- R6: Wraparound is active only when both control bit 1 and control bit 2 are set. After the end entry, execution then returns to the start-pointer entry and repeats indefinitely. If only one of the two bits is set, the queue ends at the end entry.
- R7: With loop mode (control bit 3) set, each received byte equals the byte sent. The MOSI, SCK and chip-select pins behave exactly as in normal operation.
- R8: Setting the halt bit (control bit 5) during a running queue lets the current frame complete. The halt-acknowledge flag (status bit 1) then sets, and no new frame starts while halt stays set. Clearing halt resumes with the entry that would have come next. The flag stays set until it is cleared by writing 1.
- R9: The mode-fault flag (status bit 2) sets when `mfault_in` is high while the block is enabled. `irq` is high when control bit 4 is set and either the halt-acknowledge flag or the mode-fault flag is set. `irq` is low whenever control bit 4 is clear.
- R10: After reset the control register, the pointers and the status flags read 0. Chip select is high, SCK is low and `irq` is low.
- R11: The entry index counts modulo 16, so with an end pointer below the start pointer the queue passes from entry 15 to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered register read data |
| ram_we | input | 1 | Transmit queue RAM write strobe |
| ram_waddr | input | 4 | Transmit queue RAM write index |
| ram_wdata | input | 8 | Transmit byte to store |
| ram_raddr | input | 4 | Receive RAM read index |
| ram_rdata | output | 8 | Registered receive RAM read data |
| mfault_in | input | 1 | Mode-fault indication from the bus |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Gated interrupt |

## Verification
Register and receive-RAM reads return data one clock after the address. The bench presents the address on a falling edge and samples on the next falling edge. Status flags set one clock after chip select is released at the end of an entry, and `irq` follows one clock after its flag. The bench therefore polls status, or waits a few clocks, before it samples. Serial results are captured by a bench slave that samples on SCK edges and frames on chip select, so no check depends on the exact clock in which a bit is sent.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STARTP = 2'd1;
  localparam logic [1:0] ADDR_ENDP   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_WEN  = 1;
  localparam int CB_WTO  = 2;
  localparam int CB_LOOP = 3;
  localparam int CB_IRQE = 4;
  localparam int CB_HALT = 5;
  localparam int CTRL_W  = 6;

  localparam int SB_DONE = 0;
  localparam int SB_HACK = 1;
  localparam int SB_MF   = 2;
  localparam int STAT_W  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_SHIFT, S_END, S_GAP, S_HALT
  } seq_state_t;
endpackage

// File: rtl/qseq_dpram.sv
module qseq_dpram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qseq_regs.sv
module qseq_regs
  import qseq_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          evt_done,
  input  logic          evt_hack,
  input  logic          mfault_in,
  output logic          enable,
  output logic          wrap,
  output logic          loop,
  output logic          halt,
  output logic          irq_en,
  output logic [QW-1:0] startp,
  output logic [QW-1:0] endp,
  output logic          startp_wr,
  output logic [STAT_W-1:0] flags,
  output logic          irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [QW-1:0]     startp_q, endp_q;
  logic [STAT_W-1:0] flag_q, flag_set, flag_clr;

  assign enable    = ctrl_q[CB_EN];
  assign wrap      = ctrl_q[CB_WEN] & ctrl_q[CB_WTO];
  assign loop      = ctrl_q[CB_LOOP];
  assign halt      = ctrl_q[CB_HALT];
  assign irq_en    = ctrl_q[CB_IRQE];
  assign startp    = startp_q;
  assign endp      = endp_q;
  assign flags     = flag_q;
  assign startp_wr = cpu_we && (cpu_addr == ADDR_STARTP);

  always_comb begin
    flag_set = '0;
    flag_set[SB_DONE] = evt_done;
    flag_set[SB_HACK] = evt_hack;
    flag_set[SB_MF]   = mfault_in & ctrl_q[CB_EN];
    flag_clr = (cpu_we && cpu_addr == ADDR_STAT) ? cpu_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      startp_q  <= '0;
      endp_q    <= '0;
      flag_q    <= '0;
      irq       <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (cpu_we && cpu_addr == ADDR_CTRL)   ctrl_q   <= cpu_wdata[CTRL_W-1:0];
      if (startp_wr)                         startp_q <= cpu_wdata[QW-1:0];
      if (cpu_we && cpu_addr == ADDR_ENDP)   endp_q   <= cpu_wdata[QW-1:0];
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      irq    <= ctrl_q[CB_IRQE] & (flag_q[SB_HACK] | flag_q[SB_MF]);
      case (cpu_addr)
        ADDR_CTRL:   cpu_rdata <= 8'(ctrl_q);
        ADDR_STARTP: cpu_rdata <= 8'(startp_q);
        ADDR_ENDP:   cpu_rdata <= 8'(endp_q);
        default:     cpu_rdata <= 8'(flag_q);
      endcase
    end
  end

  AST_STARTP_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr == ADDR_STARTP) |=> (cpu_rdata[7:4] == 4'd0)); // R1
endmodule

// File: rtl/qseq_shifter.sv
module qseq_shifter #(
  parameter int DW  = 8,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] tx,
  input  logic          loop,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx
);
  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  logic           busy;
  logic [DW-1:0]  sr;
  logic [BCW-1:0] bcnt;
  logic [DCW-1:0] dcnt;
  logic           din;

  assign din = loop ? mosi : miso;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      sr   <= '0;
      rx   <= '0;
      bcnt <= '0;
      dcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        sr   <= tx;
        mosi <= tx[DW-1];
        bcnt <= '0;
        dcnt <= '0;
      end
    end else if (dcnt == DCW'(DIV - 1)) begin
      dcnt <= '0;
      if (!sck) begin
        sck <= 1'b1;
        rx  <= {rx[DW-2:0], din};
      end else begin
        sck <= 1'b0;
        if (bcnt == BCW'(DW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
          sr   <= {sr[DW-2:0], 1'b0};
          mosi <= sr[DW-2];
        end
      end
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  AST_DONE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> !sck); // R3
endmodule

// File: rtl/qseq_sequencer.sv
module qseq_sequencer
  import qseq_pkg::*;
#(
  parameter int QW  = 4,
  parameter int DW  = 8,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          wrap,
  input  logic          halt,
  input  logic [QW-1:0] startp,
  input  logic [QW-1:0] endp,
  input  logic          startp_wr,
  output logic [QW-1:0] tx_raddr,
  output logic          sh_start,
  input  logic          sh_done,
  input  logic [DW-1:0] sh_rx,
  output logic          rx_we,
  output logic [QW-1:0] rx_waddr,
  output logic [DW-1:0] rx_wdata,
  output logic          cs_n,
  output logic          evt_done,
  output logic          evt_hack
);
  localparam int GCW = (DIV > 1) ? $clog2(DIV) : 1;

  seq_state_t     state_q;
  logic [QW-1:0]  ptr_q, nxt;
  logic [GCW-1:0] gcnt_q;
  logic           armed_q, pend_q, last, consume;

  assign tx_raddr = ptr_q;
  assign sh_start = (state_q == S_LOAD);
  assign rx_we    = (state_q == S_END);
  assign rx_waddr = ptr_q;
  assign rx_wdata = sh_rx;

  always_comb begin
    last = 1'b0;
    if (pend_q)              nxt = startp;
    else if (ptr_q == endp) begin
      nxt  = startp;
      last = !wrap;
    end else                 nxt = ptr_q + 1'b1;
  end

  assign consume = (state_q == S_END) ||
                   (state_q == S_HALT && enable && !halt) ||
                   (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (startp_wr && state_q != S_IDLE) pend_q <= 1'b1;
    else if (consume) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    evt_done <= 1'b0;
    evt_hack <= 1'b0;
    if (rst) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      gcnt_q  <= '0;
      armed_q <= 1'b1;
      cs_n    <= 1'b1;
    end else begin
      case (state_q)
        S_IDLE: begin
          cs_n <= 1'b1;
          if (!enable) armed_q <= 1'b1;
          else if (armed_q && !halt) begin
            ptr_q   <= startp;
            armed_q <= 1'b0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: state_q <= S_LOAD;
        S_LOAD: begin
          cs_n    <= 1'b0;
          state_q <= S_SHIFT;
        end
        S_SHIFT: if (sh_done) state_q <= S_END;
        S_END: begin
          cs_n   <= 1'b1;
          ptr_q  <= nxt;
          gcnt_q <= '0;
          if (last) begin
            evt_done <= 1'b1;
            state_q  <= S_IDLE;
          end else if (!enable) begin
            state_q <= S_IDLE;
          end else if (halt) begin
            evt_hack <= 1'b1;
            state_q  <= S_HALT;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (gcnt_q == GCW'(DIV - 1)) state_q <= S_FETCH;
          else gcnt_q <= gcnt_q + 1'b1;
        end
        S_HALT: begin
          gcnt_q <= '0;
          if (!enable) state_q <= S_IDLE;
          else if (!halt) begin
            if (pend_q) ptr_q <= startp;
            state_q <= S_GAP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_CS_LOW_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT) |-> !cs_n); // R3
  AST_PTR_STABLE_IN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT && $past(state_q) == S_SHIFT) |-> $stable(ptr_q)); // R5
  AST_HALT_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HALT && halt && enable) |=> (state_q == S_HALT)); // R8
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int QW  = 4,
  parameter int DW  = 8,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          ram_we,
  input  logic [QW-1:0] ram_waddr,
  input  logic [DW-1:0] ram_wdata,
  input  logic [QW-1:0] ram_raddr,
  output logic [DW-1:0] ram_rdata,
  input  logic          mfault_in,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n,
  output logic          irq
);
  logic enable, wrap, loop, halt, irq_en, startp_wr;
  logic [QW-1:0] startp, endp, tx_raddr, rx_waddr;
  logic [DW-1:0] tx_rdata, rx_wdata, sh_rx;
  logic [STAT_W-1:0] flags;
  logic sh_start, sh_done, rx_we, evt_done, evt_hack;

  qseq_regs #(.QW(QW)) regs_i (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .evt_done(evt_done),
    .evt_hack(evt_hack), .mfault_in(mfault_in), .enable(enable),
    .wrap(wrap), .loop(loop), .halt(halt), .irq_en(irq_en),
    .startp(startp), .endp(endp), .startp_wr(startp_wr),
    .flags(flags), .irq(irq)
  );

  qseq_dpram #(.AW(QW), .DW(DW)) txram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(tx_raddr), .rdata(tx_rdata)
  );

  qseq_dpram #(.AW(QW), .DW(DW)) rxram_i (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  qseq_sequencer #(.QW(QW), .DW(DW), .DIV(DIV)) seq_i (
    .clk(clk), .rst(rst), .enable(enable), .wrap(wrap), .halt(halt),
    .startp(startp), .endp(endp), .startp_wr(startp_wr),
    .tx_raddr(tx_raddr), .sh_start(sh_start), .sh_done(sh_done),
    .sh_rx(sh_rx), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .cs_n(spi_cs_n), .evt_done(evt_done),
    .evt_hack(evt_hack)
  );

  qseq_shifter #(.DW(DW), .DIV(DIV)) shift_i (
    .clk(clk), .rst(rst), .start(sh_start), .tx(tx_rdata), .loop(loop),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
    .rx(sh_rx)
  );

  AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck); // R3
  AST_HACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[SB_HACK]) |-> spi_cs_n); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R9
endmodule

// File: tb/qseq_top_tb_top.sv
module qseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 4;
  localparam int DW = 8;
  localparam int DIV = 2;
  localparam int NVEC = 6;
  // {start[15:12], end[11:8], control bits without enable[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0300, 16'h5500, 16'hE100, 16'h2608, 16'h3402, 16'h7A04
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic ram_we = 1'b0;
  logic [QW-1:0] ram_waddr = '0, ram_raddr = '0;
  logic [DW-1:0] ram_wdata = '0, ram_rdata;
  logic mfault_in = 1'b0, spi_sck, spi_mosi, spi_cs_n, irq;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0;
  int frame_cnt = 0, viol = 0;
  logic [7:0] frames [64];
  int fbits [64];
  logic [7:0] s_sh, s_cap;
  int s_bits;

  qseq_top #(.QW(QW), .DW(DW), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata), .mfault_in(mfault_in), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] txv(input int i);
    return 8'((i * 23 + 17) & 255);
  endfunction
  function automatic logic [7:0] resp(input int k);
    return 8'(((k * 37) & 255) ^ 8'h5A);
  endfunction

  // SPI mode-0 slave model
  always @(negedge spi_cs_n) begin
    s_sh = resp(frame_cnt); spi_miso = s_sh[7]; s_bits = 0; s_cap = '0;
  end
  always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
    s_sh = {s_sh[6:0], 1'b0}; spi_miso = s_sh[7];
  end
  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    s_cap = {s_cap[6:0], spi_mosi}; s_bits++;
  end
  always @(posedge spi_cs_n) if (!rst) begin
    if (frame_cnt < 64) begin frames[frame_cnt] = s_cap; fbits[frame_cnt] = s_bits; end
    frame_cnt++;
  end
  always @(negedge clk) if (spi_cs_n === 1'b1 && spi_sck === 1'b1) viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask
  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a;
    @(negedge clk); d = cpu_rdata;
  endtask
  task automatic ram_wr(input int a, input logic [7:0] d);
    @(negedge clk); ram_we = 1'b1; ram_waddr = QW'(a); ram_wdata = d;
    @(negedge clk); ram_we = 1'b0;
  endtask
  task automatic ram_rd(input int a, output logic [7:0] d);
    @(negedge clk); ram_raddr = QW'(a);
    @(negedge clk); d = ram_rdata;
  endtask
  task automatic wait_flag(input int b, output bit got);
    logic [7:0] st;
    got = 1'b0;
    for (int i = 0; i < 4000 && !got; i++) begin
      cpu_rd(2'd3, st);
      got = st[b];
    end
  endtask
  task automatic wait_frames(input int n);
    for (int i = 0; i < 20000 && frame_cnt < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input int v);
    logic [7:0] d;
    bit got;
    int s, e, n, bad, badb, badr;
    logic [7:0] c;
    string tag;
    s = int'(VEC[v][15:12]); e = int'(VEC[v][11:8]); c = VEC[v][7:0];
    tag = (c[3]) ? "R7" : (c[2] || c[1]) ? "R6" : (e < s) ? "R11" : "R2";
    cpu_wr(2'd0, 8'h00); cpu_wr(2'd3, 8'h07);
    repeat (5) @(negedge clk);
    frame_cnt = 0;
    cpu_wr(2'd1, 8'(s)); cpu_wr(2'd2, 8'(e)); cpu_wr(2'd0, c | 8'h01);
    wait_flag(0, got);
    chk(got, $sformatf("R2 queue-finished flag vec%0d", v), int'(got), 1);
    repeat (100) @(negedge clk);
    n = ((e - s) & 15) + 1;
    chk(frame_cnt == n, $sformatf("%s frame count vec%0d", tag, v), frame_cnt, n);
    bad = 0; badb = 0; badr = 0;
    for (int k = 0; k < n && k < 64; k++) begin
      if (frames[k] !== txv((s + k) & 15)) bad++;
      if (fbits[k] != 8) badb++;
      ram_rd((s + k) & 15, d);
      if (d !== (c[3] ? txv((s + k) & 15) : resp(k))) badr++;
    end
    chk(bad == 0, $sformatf("R3 MOSI bytes/order vec%0d", v), bad, 0);
    chk(badb == 0, $sformatf("R3 8 clocks per frame vec%0d", v), badb, 0);
    chk(badr == 0, $sformatf("%s receive RAM vec%0d", c[3] ? "R7" : "R4", v), badr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit got;
    int fc, exp_idx, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n === 1'b1, "R10 cs_n after reset", int'(spi_cs_n), 1);
    chk(spi_sck === 1'b0, "R10 sck after reset", int'(spi_sck), 0);
    chk(irq === 1'b0, "R10 irq after reset", int'(irq), 0);
    cpu_rd(2'd0, d); chk(d == 8'h00, "R10 control after reset", int'(d), 0);
    cpu_rd(2'd1, d); chk(d == 8'h00, "R10 start ptr after reset", int'(d), 0);
    cpu_rd(2'd3, d); chk(d == 8'h00, "R10 status after reset", int'(d), 0);
    // R1 upper bits of the start pointer
    cpu_wr(2'd1, 8'hFB); cpu_rd(2'd1, d);
    chk(d == 8'h0B, "R1 start ptr readback", int'(d), 8'h0B);

    for (int i = 0; i < 16; i++) ram_wr(i, txv(i));
    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R5 redirect while running
    cpu_wr(2'd0, 8'h00); cpu_wr(2'd3, 8'h07);
    repeat (5) @(negedge clk);
    frame_cnt = 0;
    cpu_wr(2'd1, 8'd0); cpu_wr(2'd2, 8'd15); cpu_wr(2'd0, 8'h01);
    @(negedge spi_cs_n); repeat (5) @(negedge clk);
    cpu_wr(2'd1, 8'd12);
    wait_flag(0, got);
    repeat (100) @(negedge clk);
    chk(frame_cnt == 5, "R5 frames after redirect", frame_cnt, 5);
    bad = (frames[0] !== txv(0)) ? 1 : 0;
    for (int k = 1; k < 5; k++) if (frames[k] !== txv(11 + k)) bad++;
    chk(bad == 0, "R5 entry order after redirect", bad, 0);

    // R6 wraparound with both bits, then R8 halt and R9 irq
    cpu_wr(2'd0, 8'h00); cpu_wr(2'd3, 8'h07);
    repeat (5) @(negedge clk);
    frame_cnt = 0;
    cpu_wr(2'd1, 8'd9); cpu_wr(2'd2, 8'd10); cpu_wr(2'd0, 8'h07);
    wait_frames(5);
    bad = 0;
    for (int k = 0; k < 5; k++) if (frames[k] !== txv((k % 2 == 0) ? 9 : 10)) bad++;
    chk(bad == 0, "R6 wrap repeats start..end", bad, 0);
    cpu_rd(2'd3, d); chk(d[0] == 1'b0, "R6 no finish while wrapping", int'(d[0]), 0);
    cpu_wr(2'd0, 8'h27);
    wait_flag(1, got);
    chk(got, "R8 halt acknowledge sets", int'(got), 1);
    chk(spi_cs_n === 1'b1, "R8 cs released at halt", int'(spi_cs_n), 1);
    fc = frame_cnt;
    repeat (200) @(negedge clk);
    chk(frame_cnt == fc, "R8 no frame while halted", frame_cnt, fc);
    chk(irq === 1'b0, "R9 irq off with enable bit clear", int'(irq), 0);
    cpu_wr(2'd0, 8'h37);
    repeat (3) @(negedge clk);
    chk(irq === 1'b1, "R9 irq from halt ack", int'(irq), 1);
    cpu_wr(2'd0, 8'h17);
    exp_idx = (fc % 2 == 0) ? 9 : 10;
    wait_frames(fc + 1);
    chk(frames[fc] === txv(exp_idx), "R8 resume at next entry", int'(frames[fc]), int'(txv(exp_idx)));
    cpu_rd(2'd3, d); chk(d[1] == 1'b1, "R8 halt ack sticky", int'(d[1]), 1);
    cpu_wr(2'd3, 8'h02);
    cpu_rd(2'd3, d); chk(d[1] == 1'b0, "R8 halt ack cleared by write 1", int'(d[1]), 0);
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R9 irq drops after clear", int'(irq), 0);
    cpu_wr(2'd0, 8'h00);
    repeat (200) @(negedge clk);

    // R9 mode fault
    cpu_wr(2'd3, 8'h07);
    cpu_wr(2'd1, 8'd0); cpu_wr(2'd2, 8'd0); cpu_wr(2'd0, 8'h11);
    @(negedge clk); mfault_in = 1'b1; @(negedge clk); mfault_in = 1'b0;
    repeat (3) @(negedge clk);
    cpu_rd(2'd3, d); chk(d[2] == 1'b1, "R9 mode fault flag", int'(d[2]), 1);
    chk(irq === 1'b1, "R9 irq from mode fault", int'(irq), 1);
    cpu_wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    chk(irq === 1'b0, "R9 irq after mode fault clear", int'(irq), 0);
    cpu_wr(2'd0, 8'h01);
    @(negedge clk); mfault_in = 1'b1; @(negedge clk); mfault_in = 1'b0;
    repeat (3) @(negedge clk);
    cpu_rd(2'd3, d); chk(d[2] == 1'b1, "R9 mode fault flag again", int'(d[2]), 1);
    chk(irq === 1'b0, "R9 irq gated off", int'(irq), 0);
    repeat (200) @(negedge clk);

    chk(viol == 0, "R3 sck high while deselected", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule